// File: doc/BRIEF.md
# Searchable Store Buffer Queue

This block is a small first-in first-out queue of pending stores that sits next to a level-one data cache. Every store the processor issues is written into the queue rather than into the cache. Each entry keeps the store's address and data word. Background logic drains the queue in arrival order from a head port and retires each entry into the cache or into memory.

A load does not wait for the queue to drain. In the cycle the load arrives, its address is compared against every occupied entry while the cache lookup runs in parallel. If one or more entries match, the data of the most recently written match is returned, and the caller must use it instead of the cache result. If nothing matches, the search reports a miss and the caller uses the cache.

Address matching works on word addresses: the two lowest byte-offset bits are ignored. The search is purely combinational from the stored contents, so a store entering the queue in the same cycle cannot be seen by that cycle's search. When the queue is full the enqueue-ready output is low and the processor must stall. This holds even if a dequeue happens in the same cycle, so the ready output never depends on the dequeue input.

Top module: `store_buffer_q`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the queue is empty: `head_valid` is 0, `enq_ready` is 1 and `srch_hit` is 0.
- R2: A store is accepted on a rising edge where `enq_valid` and `enq_ready` are both 1. From the next cycle its address and data are held in the queue.
- R3: `enq_ready` is 0 exactly when DEPTH entries are occupied. With the queue full, a store offered in the same cycle as a dequeue is refused, and the occupancy then drops by one.
- R4: `head_addr`/`head_data` show the oldest occupied entry while `head_valid` is 1. `deq` removes it on the rising edge. `deq` on an empty queue has no effect.
- R5: `srch_hit` is 1 when some occupied entry has `addr[ADDR_W-1:2]` equal to `srch_addr[ADDR_W-1:2]`. Bits [1:0] are ignored. `srch_data` is then the data of the most recently accepted such entry.
- R6: When no occupied entry matches, `srch_hit` is 0 and `srch_data` is all zeros.
- R7: A store being accepted in the current cycle does not affect that cycle's search result.
- R8: When the queue is not full, an accepted store and a dequeue of a non-empty queue may happen on the same edge. Both take effect and the occupancy is unchanged.
- R9: Youngest-match selection stays correct when the occupied entries wrap past the last storage slot.
- R10: A dequeued entry no longer takes part in the search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | A store is offered |
| enq_ready | output | 1 | Queue can accept a store |
| enq_addr | input | ADDR_W | Byte address of the offered store |
| enq_data | input | DATA_W | Data word of the offered store |
| srch_addr | input | ADDR_W | Load address to look up |
| srch_hit | output | 1 | Some occupied entry matches the load word address |
| srch_data | output | DATA_W | Data of the youngest matching entry, zero on a miss |
| head_valid | output | 1 | The queue holds at least one entry |
| head_addr | output | ADDR_W | Address of the oldest entry |
| head_data | output | DATA_W | Data of the oldest entry |
| deq | input | 1 | Remove the oldest entry |

## Verification
The assertions assume that `enq_valid`, `deq` and the address and data inputs are stable around the rising edge. They also assume that reset is applied before any traffic, and that the caller may raise `deq` on an empty queue, which the block must tolerate. The bench drives every input half a cycle away from the active edge, and starts each run with several reset cycles. It deliberately issues dequeues on an empty queue and enqueues on a full one. The store addresses are drawn from three words with random byte offsets, so repeated matches, offset-insensitive matches and wrapped pointers occur often. Misses are probed with a word address that is never stored.

// File: rtl/stb_pkg.sv
package stb_pkg;

    // Number of low address bits that select a byte inside a word.
    localparam int unsigned BYTE_OFS_W = 2;

    // Slot holding the entry of a given age, where age 0 is the youngest
    // (just behind the tail pointer) and age depth-1 the oldest.
    function automatic int unsigned slot_at_age(
        input int unsigned tail,
        input int unsigned age,
        input int unsigned depth
    );
        return (tail + depth - 1 - age) % depth;
    endfunction

endpackage

// File: rtl/stb_occupancy.sv
module stb_occupancy #(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    output logic [PW-1:0] head_ptr,
    output logic [PW-1:0] tail_ptr,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);

    logic [PW-1:0] head_q, tail_q;
    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (push) begin
                tail_q <= (tail_q == LAST_SLOT) ? '0 : tail_q + 1'b1;
            end
            if (pop) begin
                head_q <= (head_q == LAST_SLOT) ? '0 : head_q + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign head_ptr = head_q;
    assign tail_ptr = tail_q;
    assign count    = count_q;
    assign full     = (count_q == FULL_CNT);
    assign empty    = (count_q == '0);

endmodule

// File: rtl/stb_slots.sv
module stb_slots #(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          push,
    input  logic                          pop,
    input  logic [PW-1:0]                 wr_ptr,
    input  logic [PW-1:0]                 rd_ptr,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [DEPTH-1:0]              slot_valid,
    output logic [DEPTH-1:0][ADDR_W-1:0]  slot_addr,
    output logic [DEPTH-1:0][DATA_W-1:0]  slot_data
);

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic is_wr, is_rd;
        assign is_wr = push && (wr_ptr == PW'(s));
        assign is_rd = pop  && (rd_ptr == PW'(s));

        // Occupancy flag: set on write, cleared when drained.
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_valid[s] <= 1'b0;
            end else if (is_wr) begin
                slot_valid[s] <= 1'b1;
            end else if (is_rd) begin
                slot_valid[s] <= 1'b0;
            end
        end

        // Payload needs no reset: it is only looked at while the flag is set.
        always_ff @(posedge clk) begin
            if (is_wr) begin
                slot_addr[s] <= wr_addr;
                slot_data[s] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/stb_youngest.sv
module stb_youngest
    import stb_pkg::*;
#(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [PW-1:0]                 tail_ptr,
    input  logic [DEPTH-1:0]              slot_valid,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  slot_addr,
    input  logic [DEPTH-1:0][DATA_W-1:0]  slot_data,
    input  logic [ADDR_W-1:0]             key,
    output logic                          hit,
    output logic [DATA_W-1:0]             hit_data
);

    logic [DEPTH-1:0] match_vec;

    // One word-address comparator per slot.
    for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
        assign match_vec[s] = slot_valid[s] &&
            (slot_addr[s][ADDR_W-1:BYTE_OFS_W] == key[ADDR_W-1:BYTE_OFS_W]);
    end

    // Walk from the oldest age to the youngest; a later match overrides an
    // earlier one, so the entry nearest the tail wins.
    logic [PW-1:0] idx;
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        idx      = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            idx = PW'(slot_at_age(32'(tail_ptr), k, DEPTH));
            if (match_vec[idx]) begin
                hit      = 1'b1;
                hit_data = slot_data[idx];
            end
        end
    end

endmodule

// File: rtl/store_buffer_q.sv
module store_buffer_q #(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enq_valid,
    output logic              enq_ready,
    input  logic [ADDR_W-1:0] enq_addr,
    input  logic [DATA_W-1:0] enq_data,
    input  logic [ADDR_W-1:0] srch_addr,
    output logic              srch_hit,
    output logic [DATA_W-1:0] srch_data,
    output logic              head_valid,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    input  logic              deq
);

    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [PW-1:0] head_ptr, tail_ptr;
    logic [CW-1:0] occ_count;
    logic          full, empty;
    logic          push, pop;

    logic [DEPTH-1:0]             slot_valid;
    logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
    logic [DEPTH-1:0][DATA_W-1:0] slot_data;

    // Ready depends only on fullness, never on the dequeue input.
    assign enq_ready  = !full;
    assign head_valid = !empty;
    assign push       = enq_valid && !full;
    assign pop        = deq && !empty;

    stb_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .pop      (pop),
        .head_ptr (head_ptr),
        .tail_ptr (tail_ptr),
        .count    (occ_count),
        .full     (full),
        .empty    (empty)
    );

    stb_slots #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slots (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .pop        (pop),
        .wr_ptr     (tail_ptr),
        .rd_ptr     (head_ptr),
        .wr_addr    (enq_addr),
        .wr_data    (enq_data),
        .slot_valid (slot_valid),
        .slot_addr  (slot_addr),
        .slot_data  (slot_data)
    );

    stb_youngest #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_search (
        .tail_ptr   (tail_ptr),
        .slot_valid (slot_valid),
        .slot_addr  (slot_addr),
        .slot_data  (slot_data),
        .key        (srch_addr),
        .hit        (srch_hit),
        .hit_data   (srch_data)
    );

    assign head_addr = slot_addr[head_ptr];
    assign head_data = slot_data[head_ptr];

endmodule

// File: rtl/stb_checker.sv
module stb_checker #(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              enq_valid,
    input logic              enq_ready,
    input logic              deq,
    input logic              head_valid,
    input logic [ADDR_W-1:0] head_addr,
    input logic [DATA_W-1:0] head_data,
    input logic              srch_hit,
    input logic [DATA_W-1:0] srch_data,
    input logic [CW-1:0]     occ_count
);

    // R1: reset leaves the queue empty
    a_r1_reset_empty: assert property (@(posedge clk)
        rst |=> (!head_valid && enq_ready && !srch_hit));

    // R3: occupancy never exceeds the depth
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        occ_count <= CW'(DEPTH));

    // R3: a full queue refuses stores
    a_r3_full_blocks: assert property (@(posedge clk) disable iff (rst)
        (occ_count == CW'(DEPTH)) |-> !enq_ready);

    // R4: the head entry holds until it is dequeued
    a_r4_head_holds: assert property (@(posedge clk) disable iff (rst)
        (head_valid && !deq) |=> (head_valid && $stable(head_addr) && $stable(head_data)));

    // R4: dequeue on an empty queue does nothing
    a_r4_deq_empty_noop: assert property (@(posedge clk) disable iff (rst)
        (!head_valid && deq && !enq_valid) |=> !head_valid);

    // R6: a miss returns zero data
    a_r6_miss_zero: assert property (@(posedge clk) disable iff (rst)
        !srch_hit |-> (srch_data == '0));

    // R8: accept without drain grows occupancy by one
    a_r8_count_up: assert property (@(posedge clk) disable iff (rst)
        (enq_valid && enq_ready && !(deq && head_valid)) |=> (occ_count == $past(occ_count) + 1'b1));

    // R8: accept together with drain keeps occupancy
    a_r8_count_same: assert property (@(posedge clk) disable iff (rst)
        (enq_valid && enq_ready && deq && head_valid) |=> $stable(occ_count));

    // R10: nothing can match in an empty queue
    a_r10_empty_no_hit: assert property (@(posedge clk) disable iff (rst)
        !head_valid |-> !srch_hit);

endmodule

bind store_buffer_q stb_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .enq_valid  (enq_valid),
    .enq_ready  (enq_ready),
    .deq        (deq),
    .head_valid (head_valid),
    .head_addr  (head_addr),
    .head_data  (head_data),
    .srch_hit   (srch_hit),
    .srch_data  (srch_data),
    .occ_count  (occ_count)
);

// File: tb/store_buffer_q_tb.sv
module store_buffer_q_tb;

    localparam int DEPTH = 4;
    localparam int AW    = 32;
    localparam int DW    = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          enq_valid, enq_ready, deq;
    logic [AW-1:0] enq_addr, srch_addr, head_addr;
    logic [DW-1:0] enq_data, srch_data, head_data;
    logic          srch_hit, head_valid;

    always #10 clk = ~clk;

    store_buffer_q #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst),
        .enq_valid(enq_valid), .enq_ready(enq_ready),
        .enq_addr(enq_addr), .enq_data(enq_data),
        .srch_addr(srch_addr), .srch_hit(srch_hit), .srch_data(srch_data),
        .head_valid(head_valid), .head_addr(head_addr), .head_data(head_data),
        .deq(deq)
    );

    // Reference queue, oldest at index 0.
    logic [AW-1:0] mq_a[$];
    logic [DW-1:0] mq_d[$];

    int checks = 0;
    int fails  = 0;
    logic [31:0] rng = 32'h1357_9bdf;
    int unsigned serial = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic check_state();
        chk(enq_ready == (mq_a.size() < DEPTH), "R3 enq_ready", 64'(enq_ready), 64'(mq_a.size() < DEPTH));
        chk(head_valid == (mq_a.size() > 0), "R4 head_valid", 64'(head_valid), 64'(mq_a.size() > 0));
        if (mq_a.size() > 0) begin
            chk(head_addr == mq_a[0] && head_data == mq_d[0], "R4 head entry",
                {head_addr, head_data}, {mq_a[0], mq_d[0]});
        end
    endtask

    task automatic probe(input logic [AW-1:0] key, input string tag);
        bit            eh;
        logic [DW-1:0] ed;
        eh = 1'b0;
        ed = '0;
        for (int i = 0; i < mq_a.size(); i++) begin
            if (mq_a[i][AW-1:2] == key[AW-1:2]) begin
                eh = 1'b1;
                ed = mq_d[i];
            end
        end
        srch_addr = key;
        #1;
        chk(srch_hit == eh && srch_data == ed, tag,
            {31'b0, srch_hit, srch_data}, {31'b0, eh, ed});
    endtask

    // Called just after a falling edge.
    task automatic drive(input bit ev, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit dq);
        enq_valid = ev;
        enq_addr  = a;
        enq_data  = d;
        deq       = dq;
        #1;
    endtask

    task automatic commit();
        bit do_push, do_pop;
        do_push = enq_valid && (mq_a.size() < DEPTH);
        do_pop  = deq && (mq_a.size() > 0);
        @(posedge clk);
        if (do_pop) begin
            void'(mq_a.pop_front());
            void'(mq_d.pop_front());
        end
        if (do_push) begin
            mq_a.push_back(enq_addr);
            mq_d.push_back(enq_data);
        end
        @(negedge clk);
        enq_valid = 1'b0;
        deq       = 1'b0;
    endtask

    task automatic step(input bit ev, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit dq);
        drive(ev, a, d, dq);
        check_state();
        probe(32'h100, "R5 search word0");
        probe(32'h107, "R5 search word1 offset");
        probe(32'h10A, "R5 search word2 offset");
        probe(32'h10C, "R6 search miss");
        commit();
    endtask

    initial begin : main
        rst = 1'b1; enq_valid = 1'b0; deq = 1'b0;
        enq_addr = '0; enq_data = '0; srch_addr = 32'h100;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk(!head_valid && enq_ready && !srch_hit, "R1 reset state",
            {61'b0, head_valid, enq_ready, srch_hit}, 64'b010);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(!head_valid && enq_ready && !srch_hit, "R1 after release",
            {61'b0, head_valid, enq_ready, srch_hit}, 64'b010);

        // R4: dequeue on empty is ignored
        step(1'b0, '0, '0, 1'b1);
        #1;
        chk(!head_valid, "R4 deq on empty", 64'(head_valid), 64'd0);

        // R2: accepted store appears next cycle
        step(1'b1, 32'h200, 32'hA1, 1'b0);
        #1;
        chk(head_valid && head_addr == 32'h200 && head_data == 32'hA1, "R2 store held",
            {head_addr, head_data}, {32'h200, 32'hA1});

        // R7: a store entering this cycle is invisible to this cycle's search
        drive(1'b1, 32'h300, 32'hB2, 1'b0);
        probe(32'h300, "R7 same-cycle store not visible");
        commit();
        probe(32'h301, "R7 visible one cycle later");

        // R3: fill to full, then enqueue together with dequeue is refused
        step(1'b1, 32'h104, 32'hC3, 1'b0);
        step(1'b1, 32'h104, 32'hC4, 1'b0);
        drive(1'b1, 32'h108, 32'hC5, 1'b1);
        chk(!enq_ready, "R3 full ready low", 64'(enq_ready), 64'd0);
        commit();
        #1;
        chk(enq_ready && mq_a.size() == DEPTH - 1, "R3 refused store, one drained",
            64'(enq_ready), 64'd1);
        probe(32'h108, "R3 refused store not stored");

        // R8: enqueue and dequeue together when not full
        drive(1'b1, 32'h108, 32'hC6, 1'b1);
        commit();
        #1;
        chk(mq_a.size() == DEPTH - 1 && enq_ready, "R8 occupancy unchanged", 64'(enq_ready), 64'd1);
        check_state();

        // R9: duplicates across the wrap point, youngest wins
        step(1'b1, 32'h104, 32'hD1, 1'b0);
        step(1'b0, '0, '0, 1'b1);
        step(1'b0, '0, '0, 1'b1);
        step(1'b1, 32'h105, 32'hD2, 1'b0);
        step(1'b1, 32'h106, 32'hD3, 1'b0);
        probe(32'h104, "R9 wrapped youngest match");

        // R10: drain everything, nothing matches afterwards
        for (int i = 0; i < DEPTH; i++) step(1'b0, '0, '0, 1'b1);
        probe(32'h104, "R10 drained entry gone");
        probe(32'h108, "R10 drained entry gone");

        // Near-exhaustive pseudo-random sweep over the three-word set.
        for (int n = 0; n < 800; n++) begin
            bit            ev, dq;
            logic [AW-1:0] a;
            rng    = next_rng(rng);
            ev     = (rng[3:0] < 4'd9);
            dq     = (rng[7:4] < 4'd7);
            a      = 32'h100 + 32'(4 * (rng[11:8] % 3)) + 32'(rng[13:12]);
            serial++;
            step(ev, a, 32'hE000_0000 + serial, dq);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule